// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes for a network controller and drives one level-sensitive interrupt line. It has two 32-bit registers: a cause register and a mask register. Hardware event strobes and software writes set bits in the cause register. Software controls the mask through one offset that sets bits and another that clears them. The interrupt line is high whenever at least one cause bit is both pending and enabled by the mask.

Reading the cause register returns its value and then clears it. Completed receive packets also add to a pending receive-event counter. After each clear-on-read, if that counter is non-zero, the receive-timer cause is raised again and the counter drops by one. Packet completions that one read would have merged are therefore handed back to software one read at a time.

Software reaches both registers through a generic single-cycle register port. Read data is combinational in the cycle the read strobe is high. Register updates take effect at the next clock edge.

Top module: `irq_cause_ctl`

## Requirements
- R1: After reset the cause register, the mask register and the pending receive count are all zero, and `irq` is low.
- R2: A read at offset 0xC0 returns the cause value in the same cycle. From the next cycle all cause bits are cleared, except bits re-raised by R3 or set in that same cycle by R9 or R4.
- R3: When a cause read happens while the pending receive count is non-zero, cause bit 7 is set again after the clear and the count drops by one.
- R4: A pulse on `rx_done` sets cause bit 7 and adds one to the pending receive count. The count saturates at 2^RXCNT_W-1.
- R5: A write at offset 0xC8 ORs the written data into the cause register.
- R6: A write at offset 0xD0 ORs the written data into the mask. A read at 0xD0 returns the mask and changes no state.
- R7: A write at offset 0xD8 clears every mask bit that is 1 in the written data.
- R8: `irq` is high exactly when (cause AND mask) is non-zero. It reflects each change one clock after the access or event that caused it.
- R9: Any bit set on `hw_event` is ORed into the cause register. The bit survives a cause read made in the same cycle.
- R10: Reads at offset 0xC8, at offset 0xD8 and at any unmapped offset return zero. Writes to offset 0xC0 or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| hw_event | input | 32 | Per-bit hardware cause strobes |
| rx_done | input | 1 | Receive packet completion pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the cycle in which a cause read collides with a hardware event or a receive completion. A design that applied the clear last would silently lose that event. It drives the pending receive count past saturation and then reads back one bit-7 cause per read until the count runs dry. A counter that wrapped would stop re-raising too early, and one that never decremented would interrupt forever. It also sweeps every cause bit against set and clear of the same mask bit. A swapped set/clear offset or a mask applied to the wrong bit shows up as a wrong `irq` level. Write-only and unmapped offsets are read back, and the cause offset is written, to catch decode aliasing.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int WORD_W = 32;

  // register byte offsets
  localparam int OFS_CAUSE_RD  = 'hC0;
  localparam int OFS_CAUSE_SET = 'hC8;
  localparam int OFS_MASK_SET  = 'hD0;
  localparam int OFS_MASK_CLR  = 'hD8;

  // cause bit positions
  localparam int CB_TX_WB    = 0;
  localparam int CB_TX_EMPTY = 1;
  localparam int CB_LINK     = 2;
  localparam int CB_RX_OVR   = 6;
  localparam int CB_RX_TMR   = 7;
  localparam int CB_MGMT     = 9;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic              rd_cause,
  output logic              rd_mask,
  output logic              wr_cause_set,
  output logic              wr_mask_set,
  output logic              wr_mask_clr
);
  localparam logic [ADDR_W-1:0] A_CRD = ADDR_W'(OFS_CAUSE_RD);
  localparam logic [ADDR_W-1:0] A_CST = ADDR_W'(OFS_CAUSE_SET);
  localparam logic [ADDR_W-1:0] A_MST = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_MCL = ADDR_W'(OFS_MASK_CLR);

  always_comb begin
    rd_cause     = reg_rd && (reg_addr == A_CRD);
    rd_mask      = reg_rd && (reg_addr == A_MST);
    wr_cause_set = reg_wr && (reg_addr == A_CST);
    wr_mask_set  = reg_wr && (reg_addr == A_MST);
    wr_mask_clr  = reg_wr && (reg_addr == A_MCL);
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_cause_pkg::*;
#(
  parameter int RXCNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_rd,
  input  logic               set_wr,
  input  word_t              wdata,
  input  word_t              hw_event,
  input  logic               rx_done,
  output word_t              cause_q,
  output word_t              cause_d,
  output logic [RXCNT_W-1:0] rxcnt_q
);
  localparam logic [RXCNT_W-1:0] CNT_MAX = '1;

  logic [RXCNT_W-1:0] rxcnt_d;
  logic               rearm;
  logic               cause_en;
  logic               cnt_en;

  always_comb begin
    rearm   = clr_rd && (rxcnt_q != '0);
    cause_d = clr_rd ? '0 : cause_q;
    if (rearm)   cause_d[CB_RX_TMR] = 1'b1;
    if (set_wr)  cause_d = cause_d | wdata;
    cause_d = cause_d | hw_event;
    if (rx_done) cause_d[CB_RX_TMR] = 1'b1;
    cause_en = clr_rd || set_wr || rx_done || (|hw_event);

    rxcnt_d = rxcnt_q;
    cnt_en  = 1'b0;
    if (rx_done && !rearm) begin
      if (rxcnt_q != CNT_MAX) begin
        rxcnt_d = rxcnt_q + 1'b1;
        cnt_en  = 1'b1;
      end
    end else if (!rx_done && rearm) begin
      rxcnt_d = rxcnt_q - 1'b1;
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxcnt_q <= '0;
    end else if (cnt_en) begin
      rxcnt_q <= rxcnt_d;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_cause_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_wr,
  input  logic  clr_wr,
  input  word_t wdata,
  output word_t mask_q,
  output word_t mask_d
);
  logic mask_en;

  always_comb begin
    mask_d  = mask_q;
    if (set_wr) mask_d = mask_d | wdata;
    if (clr_wr) mask_d = mask_d & ~wdata;
    mask_en = set_wr || clr_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/irq_cause_ctl.sv
module irq_cause_ctl
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int RXCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       hw_event,
  input  logic              rx_done,
  output logic              irq
);
  logic rd_cause, rd_mask, wr_cause_set, wr_mask_set, wr_mask_clr;
  word_t cause_q, cause_d, mask_q, mask_d;
  logic [RXCNT_W-1:0] rxcnt_q;
  logic irq_d;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .rd_cause     (rd_cause),
    .rd_mask      (rd_mask),
    .wr_cause_set (wr_cause_set),
    .wr_mask_set  (wr_mask_set),
    .wr_mask_clr  (wr_mask_clr)
  );

  irq_cause_reg #(.RXCNT_W(RXCNT_W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_rd   (rd_cause),
    .set_wr   (wr_cause_set),
    .wdata    (reg_wdata),
    .hw_event (hw_event),
    .rx_done  (rx_done),
    .cause_q  (cause_q),
    .cause_d  (cause_d),
    .rxcnt_q  (rxcnt_q)
  );

  irq_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (wr_mask_set),
    .clr_wr (wr_mask_clr),
    .wdata  (reg_wdata),
    .mask_q (mask_q),
    .mask_d (mask_d)
  );

  always_comb begin
    if (rd_cause)      reg_rdata = cause_q;
    else if (rd_mask)  reg_rdata = mask_q;
    else               reg_rdata = '0;
    irq_d = |(cause_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
  parameter int ADDR_W  = 12,
  parameter int RXCNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [31:0]        hw_event,
  input logic               rx_done,
  input logic               irq,
  input logic [31:0]        cause_q,
  input logic [31:0]        mask_q,
  input logic [RXCNT_W-1:0] rxcnt_q
);
  localparam logic [ADDR_W-1:0] A_CRD = ADDR_W'('hC0);
  localparam logic [ADDR_W-1:0] A_CST = ADDR_W'('hC8);
  localparam logic [ADDR_W-1:0] A_MST = ADDR_W'('hD0);
  localparam logic [ADDR_W-1:0] A_MCL = ADDR_W'('hD8);

  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(cause_q & mask_q)));

  a_r5_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CST) |=> ((cause_q & $past(reg_wdata)) == $past(reg_wdata)));

  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MST) |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

  a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MCL) |=> ((mask_q & $past(reg_wdata)) == 32'h0));

  a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != 32'h0) |=> ((cause_q & $past(hw_event)) == $past(hw_event)));

  a_r3_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CRD && rxcnt_q != '0 && !rx_done)
      |=> (cause_q[7] && rxcnt_q == $past(rxcnt_q) - 1'b1));

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CRD && rxcnt_q == '0 && !rx_done && hw_event == 32'h0 && !reg_wr)
      |=> (cause_q == 32'h0));

  a_r10_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == A_CST || reg_addr == A_MCL)) |-> (reg_rdata == 32'h0));
endmodule

bind irq_cause_ctl irq_cause_chk #(.ADDR_W(ADDR_W), .RXCNT_W(RXCNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .hw_event  (hw_event),
  .rx_done   (rx_done),
  .irq       (irq),
  .cause_q   (cause_q),
  .mask_q    (mask_q),
  .rxcnt_q   (rxcnt_q)
);

// File: tb/irq_cause_ctl_bench.sv
module irq_cause_ctl_bench;
  localparam int ADDR_W  = 12;
  localparam int RXCNT_W = 2;
  localparam int CNTMAX  = 3;
  localparam logic [11:0] A_CRD = 12'h0C0;
  localparam logic [11:0] A_CST = 12'h0C8;
  localparam logic [11:0] A_MST = 12'h0D0;
  localparam logic [11:0] A_MCL = 12'h0D8;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_rd, rx_done;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, hw_event;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] m_cause, m_mask;
  int m_cnt;

  always #2 clk = ~clk;

  irq_cause_ctl #(.ADDR_W(ADDR_W), .RXCNT_W(RXCNT_W)) u_irq_cause_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_event(hw_event), .rx_done(rx_done), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one register-port cycle; rdata checked under tag, irq checked under R8
  task automatic op(input logic wr, input logic rd, input logic [11:0] a,
                    input logic [31:0] wd, input logic [31:0] ev, input logic rx,
                    input string tag);
    logic [31:0] exp_rd, nc;
    bit dec;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    hw_event = ev; rx_done = rx;
    #1;
    exp_rd = 32'h0;
    if (rd && a == A_CRD) exp_rd = m_cause;
    if (rd && a == A_MST) exp_rd = m_mask;
    if (rd) check(tag, reg_rdata, exp_rd);
    dec = 0;
    nc = m_cause;
    if (rd && a == A_CRD) begin
      nc = 32'h0;
      if (m_cnt != 0) begin nc[7] = 1'b1; dec = 1; end
    end
    if (wr && a == A_CST) nc = nc | wd;
    nc = nc | ev;
    if (rx) nc[7] = 1'b1;
    m_cause = nc;
    if (rx && !dec && m_cnt < CNTMAX) m_cnt++;
    if (!rx && dec) m_cnt--;
    if (wr && a == A_MST) m_mask = m_mask | wd;
    if (wr && a == A_MCL) m_mask = m_mask & ~wd;
    @(posedge clk);
    #1;
    reg_wr = 0; reg_rd = 0; rx_done = 0; hw_event = 32'h0;
    check("R8 irq", {31'h0, irq}, {31'h0, |(m_cause & m_mask)});
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [11:0] alist [6];
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    hw_event = '0; rx_done = 0;
    m_cause = '0; m_mask = '0; m_cnt = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    op(0, 1, A_CRD, 0, 0, 0, "R1 cause");
    op(0, 1, A_MST, 0, 0, 0, "R1 mask");

    // R5 R6 R7 R8 R2: walk each cause bit against its mask bit
    for (int i = 0; i < 32; i++) begin
      op(1, 0, A_CST, 32'h1 << i, 0, 0, "R5");
      op(1, 0, A_MST, 32'h1 << i, 0, 0, "R6");
      op(0, 1, A_MST, 0, 0, 0, "R6 mask read");
      op(1, 0, A_MCL, 32'h1 << i, 0, 0, "R7");
      op(0, 1, A_CRD, 0, 0, 0, "R2 read");
      op(0, 1, A_CRD, 0, 0, 0, "R2 cleared");
    end
    check("R7 mask empty", m_mask, 32'h0);

    // R9: event in the same cycle as a cause read survives
    op(1, 0, A_MST, 32'h0000_0204, 0, 0, "R6");
    op(1, 0, A_CST, 32'h0000_0041, 0, 0, "R5");
    op(0, 1, A_CRD, 0, 32'h0000_0004, 0, "R9 read with event");
    op(0, 1, A_CRD, 0, 0, 0, "R9 event kept");
    op(0, 0, A_CRD, 0, 32'h0000_0200, 0, "R9");
    op(0, 1, A_CRD, 0, 0, 0, "R9 mgmt bit");

    // R4 R3: saturating pending receive count and re-arm per read
    for (int i = 0; i < 5; i++) op(0, 0, 12'h000, 0, 0, 1, "R4");
    op(1, 0, A_MST, 32'h0000_0080, 0, 0, "R6");
    for (int i = 0; i < 4; i++) op(0, 1, A_CRD, 0, 0, 0, "R3 rearm read");
    op(0, 1, A_CRD, 0, 0, 0, "R3 drained");
    check("R4 saturation count", m_cnt, 0);
    // R3: read colliding with rx_done
    op(0, 0, 12'h000, 0, 0, 1, "R4");
    op(0, 1, A_CRD, 0, 0, 1, "R3 read with rx");
    op(0, 1, A_CRD, 0, 0, 0, "R3");
    op(0, 1, A_CRD, 0, 0, 0, "R3");
    op(0, 1, A_CRD, 0, 0, 0, "R3 end");

    // R10: write-only and unmapped reads, ignored writes
    op(1, 0, A_CST, 32'h0000_0002, 0, 0, "R5");
    op(1, 0, A_CRD, 32'hFFFF_FFFF, 0, 0, "R10");
    op(1, 0, 12'h000, 32'hFFFF_FFFF, 0, 0, "R10");
    op(0, 1, A_CST, 0, 0, 0, "R10 cause-set read");
    op(0, 1, A_MCL, 0, 0, 0, "R10 mask-clear read");
    op(0, 1, 12'h0C4, 0, 0, 0, "R10 unmapped read");
    op(0, 1, 12'h000, 0, 0, 0, "R10 unmapped read");
    op(0, 1, A_MST, 0, 0, 0, "R10 mask unchanged");
    op(0, 1, A_CRD, 0, 0, 0, "R10 cause unchanged");

    // mixed sweep from an LFSR
    alist[0] = A_CRD; alist[1] = A_CST; alist[2] = A_MST;
    alist[3] = A_MCL; alist[4] = 12'h000; alist[5] = 12'h0C4;
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ev;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ev = (lfsr[5:0] == 6'd0) ? (32'h1 << lfsr[10:6]) : 32'h0;
      op(lfsr[11], ~lfsr[11], alist[lfsr[14:12] % 6], lfsr ^ (lfsr << 7),
         ev, lfsr[20:18] == 3'd0, "R2 R6 R10 sweep");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule